// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block takes a set of external interrupt pins and turns each one into an interrupt message for a processor. Every pin has its own redirection entry. The entry sets the vector number, the delivery mode, the destination identifier, the active polarity and the trigger kind (edge or level), and it also holds a mask bit. Software never addresses the entries directly. It writes an entry number into a select register and then reads or writes the chosen word through a data window. A read-only identification word reports the version and the highest pin index.

Each pin is sampled twice by the clock. Its level is then inverted if the entry asks for active-low. An edge entry latches a pending request on an active-going transition. A level entry requests for as long as its conditioned input stays active. Requests are granted lowest index first. The grant goes out on a valid/ready message port that carries the entry's vector, destination and delivery mode.

A granted level entry becomes in-service and stays quiet until software writes an end-of-interrupt code that carries the vector. That one write releases every level entry programmed with the same vector. This lets several level sources of equal polarity share a vector. Edges that arrive while an entry is masked are thrown away.

Top module: `irq_redirector`

## Requirements
- R1: Select value 0x01 exposes the identification word through the window at offset 0x10: bits 7:0 hold the VERSION parameter, bits 23:16 hold NUM_PINS-1, and all other bits read 0.
- R2: After reset every entry is masked: its low word reads 0x0001_0000, its high word reads 0, and msg_valid is low.
- R3: Entry n has its low word at select 0x10+2n and its high word at select 0x11+2n. In the low word, bit 16 is the mask, bit 15 the trigger (1 = level), bit 13 the polarity (1 = active low), bits 10:8 the delivery mode (0 fixed, 1 lowest priority, 2 PMI, 5 INIT) and bits 7:0 the vector. The high word holds the destination in bits 31:16. All other bits read 0.
- R4: The select register at offset 0x00 reads back its 8-bit value. Select values that map to nothing read 0 through the window. Offset 0x40 (end-of-interrupt) always reads 0.
- R5: An unmasked edge entry sends exactly one message for each inactive-to-active transition of its input, however long the input then stays active.
- R6: A transition that arrives while the entry is masked is discarded. Clearing the mask later produces no message for it.
- R7: An unmasked level entry whose input is active and which is not in service requests a message. Once that message is accepted, the entry sends nothing more until it is released.
- R8: A write of vector v to offset 0x40 releases every level entry programmed with v. A released entry whose input is still active requests again. Entries with other vectors stay in service.
- R9: With polarity 1, a low input is active and a high input is inactive.
- R10: When several entries request, the lowest index is presented first. A request stays presented while msg_ready is low.
- R11: A message carries the vector, destination and delivery mode of the granted entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset: 0x00 select, 0x10 window, 0x40 end-of-interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NUM_PINS | Raw interrupt pins |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The receiver accepts the message |
| msg_vector | output | 8 | Vector of the offered message |
| msg_dest | output | 16 | Destination (ID in the upper byte, extended ID in the lower byte) |
| msg_dmode | output | 3 | Delivery mode of the offered message |

## Verification
The bound assertions check on every cycle that at most one entry is granted, and that the grant goes to the lowest requesting index. They also check that a pending edge never appears right after a cycle in which its entry was masked, that an in-service flag only rises on that entry's own grant, and that it only falls after an end-of-interrupt write. Several behaviours are visible only as sequences at the ports, so only the bench scenarios can show them: one message per edge, silence while an entry is in service, re-delivery after an end-of-interrupt write for an input that is still active, one write releasing two entries that share a vector, the polarity inversion, and the register field layout.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] OFS_EOI    = 8'h40;

  localparam logic [7:0] SEL_IDENT    = 8'h01;
  localparam logic [7:0] SEL_ENTRY_LO = 8'h10;

  localparam int B_MASK = 16;
  localparam int B_TRIG = 15;
  localparam int B_POL  = 13;
  localparam int B_DM   = 8;
  localparam int B_DEST = 16;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        trig;   // 1 = level
    logic        pol;    // 1 = active low
    logic [2:0]  dmode;
    logic [7:0]  vec;
  } entry_t;

  function automatic logic [31:0] low_word(entry_t e);
    logic [31:0] w;
    w = '0;
    w[7:0]           = e.vec;
    w[B_DM+2:B_DM]   = e.dmode;
    w[B_POL]         = e.pol;
    w[B_TRIG]        = e.trig;
    w[B_MASK]        = e.mask;
    return w;
  endfunction

  function automatic logic [31:0] high_word(entry_t e);
    return {e.dest, 16'h0000};
  endfunction

endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         N       = 8,
  parameter logic [7:0] VERSION = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output entry_t [N-1:0]    entries,
  output logic              eoi_wr,
  output logic [7:0]        eoi_vec
);
  localparam logic [8:0] WIN_SPAN = 9'(2 * N);

  logic [7:0] sel_q, sel_n;
  entry_t     ent_q [N];
  entry_t     ent_n [N];

  logic [8:0] win_off;
  logic       win_hit;
  logic [7:0] win_idx;
  logic       win_hi;
  logic [31:0] win_rd;
  logic        unused_wbits;

  assign unused_wbits = ^{wdata[14], wdata[12:11]};

  assign win_off = {1'b0, sel_q} - {1'b0, SEL_ENTRY_LO};
  assign win_hit = (sel_q >= SEL_ENTRY_LO) && (win_off < WIN_SPAN);
  assign win_idx = win_off[8:1];
  assign win_hi  = win_off[0];

  assign eoi_wr  = wr && (addr == OFS_EOI);
  assign eoi_vec = wdata[7:0];

  always_comb begin
    sel_n = sel_q;
    for (int i = 0; i < N; i++) ent_n[i] = ent_q[i];
    if (wr && addr == OFS_SELECT) sel_n = wdata[7:0];
    if (wr && addr == OFS_WINDOW && win_hit) begin
      for (int i = 0; i < N; i++) begin
        if (win_idx == 8'(i)) begin
          if (win_hi) begin
            ent_n[i].dest = wdata[B_DEST+15:B_DEST];
          end else begin
            ent_n[i].vec   = wdata[7:0];
            ent_n[i].dmode = wdata[B_DM+2:B_DM];
            ent_n[i].pol   = wdata[B_POL];
            ent_n[i].trig  = wdata[B_TRIG];
            ent_n[i].mask  = wdata[B_MASK];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int i = 0; i < N; i++) begin
        ent_q[i]      <= '0;
        ent_q[i].mask <= 1'b1;
      end
    end else begin
      sel_q <= sel_n;
      for (int i = 0; i < N; i++) ent_q[i] <= ent_n[i];
    end
  end

  always_comb begin
    win_rd = '0;
    if (sel_q == SEL_IDENT) begin
      win_rd = {8'h00, 8'(N - 1), 8'h00, VERSION};
    end else if (win_hit) begin
      for (int i = 0; i < N; i++) begin
        if (win_idx == 8'(i)) win_rd = win_hi ? high_word(ent_q[i]) : low_word(ent_q[i]);
      end
    end
  end

  always_comb begin
    case (addr)
      OFS_SELECT: rdata = {24'h0, sel_q};
      OFS_WINDOW: rdata = win_rd;
      default:    rdata = '0;
    endcase
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign entries[g] = ent_q[g];
  end

endmodule

// File: rtl/irq_redir_pin.sv
module irq_redir_pin (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_raw,
  input  logic [7:0] vec,
  input  logic       pol,
  input  logic       trig,
  input  logic       mask,
  input  logic       grant,
  input  logic       eoi_wr,
  input  logic [7:0] eoi_vec,
  output logic       req,
  output logic       pend,
  output logic       insvc
);
  logic in_q, in_qq;
  logic pend_n, insvc_n;
  logic act, act_prev, rise;

  assign act      = in_q ^ pol;
  assign act_prev = in_qq ^ pol;
  assign rise     = act & ~act_prev;

  assign req = ~mask & (trig ? (act & ~insvc) : pend);

  always_comb begin
    if (trig) pend_n = 1'b0;
    else      pend_n = (pend & ~grant) | (rise & ~mask);

    if (grant && trig)                  insvc_n = 1'b1;
    else if (eoi_wr && eoi_vec == vec)  insvc_n = 1'b0;
    else                                insvc_n = insvc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= 1'b0;
      in_qq <= 1'b0;
      pend  <= 1'b0;
      insvc <= 1'b0;
    end else begin
      in_q  <= irq_raw;
      in_qq <= in_q;
      pend  <= pend_n;
      insvc <= insvc_n;
    end
  end

endmodule

// File: rtl/irq_redir_arb.sv
module irq_redir_arb #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic          ready,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N-1:0] lowest;

  assign lowest = req & (~req + 1'b1);
  assign grant  = ready ? lowest : '0;
  assign any    = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h21,
  localparam int        IW       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [15:0]         msg_dest,
  output logic [2:0]          msg_dmode
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  entry_t [NUM_PINS-1:0] entries;
  logic                  eoi_wr;
  logic [7:0]            eoi_vec;
  logic [NUM_PINS-1:0]   req_vec, grant_vec, pend_vec, insvc_vec, mask_vec;
  logic [IW-1:0]         win_idx;

  irq_redir_regs #(.N(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .entries (entries),
    .eoi_wr  (eoi_wr),
    .eoi_vec (eoi_vec)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign mask_vec[g] = entries[g].mask;
    irq_redir_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .irq_raw (irq_in[g]),
      .vec     (entries[g].vec),
      .pol     (entries[g].pol),
      .trig    (entries[g].trig),
      .mask    (entries[g].mask),
      .grant   (grant_vec[g]),
      .eoi_wr  (eoi_wr),
      .eoi_vec (eoi_vec),
      .req     (req_vec[g]),
      .pend    (pend_vec[g]),
      .insvc   (insvc_vec[g])
    );
  end

  irq_redir_arb #(.N(NUM_PINS)) u_arb (
    .req   (req_vec),
    .ready (msg_ready),
    .grant (grant_vec),
    .idx   (win_idx),
    .any   (msg_valid)
  );

  assign msg_vector = entries[win_idx].vec;
  assign msg_dest   = entries[win_idx].dest;
  assign msg_dmode  = entries[win_idx].dmode;

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_vec,
  input logic [N-1:0] grant_vec,
  input logic [N-1:0] mask_vec,
  input logic [N-1:0] pend_vec,
  input logic [N-1:0] insvc_vec,
  input logic         eoi_wr
);

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  p_grant_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_vec) |-> (((grant_vec - 1'b1) & req_vec) == '0));

  p_masked_edge_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & ~$past(pend_vec) & $past(mask_vec)) == '0);

  p_insvc_by_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_vec & ~$past(insvc_vec) & ~$past(grant_vec)) == '0);

  p_eoi_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(insvc_vec) & ~insvc_vec)) |-> $past(eoi_wr));

endmodule

bind irq_redirector irq_redir_chk #(.N(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .req_vec   (req_vec),
  .grant_vec (grant_vec),
  .mask_vec  (mask_vec),
  .pend_vec  (pend_vec),
  .insvc_vec (insvc_vec),
  .eoi_wr    (eoi_wr)
);

// File: tb/tb_irq_redirector.sv
module tb_irq_redirector;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] irq_in;
  logic          msg_valid;
  logic          msg_ready;
  logic [7:0]    msg_vector;
  logic [15:0]   msg_dest;
  logic [2:0]    msg_dmode;

  int checks = 0;
  int fails  = 0;
  int acc    = 0;
  int last_vec = -1;
  bit done = 0;

  always #4 clk = ~clk;

  irq_redirector #(.NUM_PINS(NP), .VERSION(8'h21)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_dmode(msg_dmode)
  );

  // ---------------- behavioural reference model ----------------
  int m_vec[NP], m_dm[NP], m_pol[NP], m_trig[NP], m_mask[NP], m_dest[NP];
  int m_inq[NP], m_inqq[NP], m_pend[NP], m_isv[NP];
  int m_sel;
  int m_sync;

  function automatic int m_first_req();
    for (int i = 0; i < NP; i++) begin
      int act;
      int r;
      act = m_inq[i] ^ m_pol[i];
      if (m_mask[i] != 0)      r = 0;
      else if (m_trig[i] != 0) r = (act != 0 && m_isv[i] == 0) ? 1 : 0;
      else                     r = m_pend[i];
      if (r != 0) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0;
      m_sel  = 0;
      for (int i = 0; i < NP; i++) begin
        m_vec[i] = 0; m_dm[i] = 0; m_pol[i] = 0; m_trig[i] = 0; m_mask[i] = 1; m_dest[i] = 0;
        m_inq[i] = 0; m_inqq[i] = 0; m_pend[i] = 0; m_isv[i] = 0;
      end
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int g;
      int np[NP];
      int ni[NP];
      g = msg_ready ? m_first_req() : -1;
      for (int i = 0; i < NP; i++) begin
        int edge_seen;
        edge_seen = ((m_inq[i] ^ m_pol[i]) != 0 && (m_inqq[i] ^ m_pol[i]) == 0) ? 1 : 0;
        if (m_trig[i] != 0) np[i] = 0;
        else np[i] = ((m_pend[i] != 0 && g != i) || (edge_seen != 0 && m_mask[i] == 0)) ? 1 : 0;
        if (g == i && m_trig[i] != 0) ni[i] = 1;
        else if (bus_wr && bus_addr == 8'h40 && int'(bus_wdata[7:0]) == m_vec[i]) ni[i] = 0;
        else ni[i] = m_isv[i];
      end
      for (int i = 0; i < NP; i++) begin
        m_pend[i] = np[i];
        m_isv[i]  = ni[i];
        m_inqq[i] = m_inq[i];
        m_inq[i]  = int'(irq_in[i]);
      end
      if (bus_wr && bus_addr == 8'h00) m_sel = int'(bus_wdata[7:0]);
      else if (bus_wr && bus_addr == 8'h10 && m_sel >= 16 && m_sel < 16 + 2 * NP) begin
        int n;
        n = (m_sel - 16) / 2;
        if ((m_sel - 16) % 2 == 0) begin
          m_vec[n]  = int'(bus_wdata[7:0]);
          m_dm[n]   = int'(bus_wdata[10:8]);
          m_pol[n]  = int'(bus_wdata[13]);
          m_trig[n] = int'(bus_wdata[15]);
          m_mask[n] = int'(bus_wdata[16]);
        end else begin
          m_dest[n] = int'(bus_wdata[31:16]);
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge (R10, R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int f;
      f = m_first_req();
      checks++;
      if ((f >= 0) != msg_valid) begin
        fails++;
        $display("FAIL R10 per-cycle msg_valid actual=%0d expected=%0d", msg_valid, f >= 0);
      end else if (f >= 0 && (int'(msg_vector) != m_vec[f] || int'(msg_dest) != m_dest[f] ||
                              int'(msg_dmode) != m_dm[f])) begin
        fails++;
        $display("FAIL R11 per-cycle msg actual=%h/%h/%0d expected=%h/%h/%0d",
                 msg_vector, msg_dest, msg_dmode, m_vec[f], m_dest[f], m_dm[f]);
      end
      if (msg_valid && msg_ready) begin
        acc++;
        last_vec = int'(msg_vector);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wait_n(int n);
    repeat (n) step();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_addr(logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #2;
    v = bus_rdata;
    step();
  endtask

  task automatic rd_sel(logic [7:0] s, output logic [31:0] v);
    wr(8'h00, {24'h0, s});
    rd_addr(8'h10, v);
  endtask

  task automatic prog(int n, logic [31:0] lo, logic [31:0] hi);
    wr(8'h00, 32'(8'h11 + 2 * n)); wr(8'h10, hi);
    wr(8'h00, 32'(8'h10 + 2 * n)); wr(8'h10, lo);
  endtask

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [31:0] v;
    int a0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    irq_in = '0; msg_ready = 1'b1;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    // R2: reset state
    chk("R2 msg_valid after reset", msg_valid, 0);
    rd_sel(8'h10, v); chk("R2 entry0 low", v, 32'h0001_0000);
    rd_sel(8'h1E, v); chk("R2 entry7 low", v, 32'h0001_0000);
    rd_sel(8'h1F, v); chk("R2 entry7 high", v, 32'h0);

    // R1: identification word
    rd_sel(8'h01, v); chk("R1 ident word", v, 32'h0007_0021);

    // R4: select readback, unmapped select, EOI offset
    wr(8'h00, 32'h33); rd_addr(8'h00, v); chk("R4 select readback", v, 32'h33);
    rd_sel(8'h20, v); chk("R4 unmapped select", v, 32'h0);
    rd_addr(8'h40, v); chk("R4 eoi offset reads zero", v, 32'h0);

    // R3: field layout
    prog(2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd_sel(8'h14, v); chk("R3 low word fields", v, 32'h0001_A7FF);
    rd_sel(8'h15, v); chk("R3 high word dest", v, 32'hFFFF_0000);
    prog(2, 32'h0001_0000, 32'h0);

    // R5: edge entry, one message per transition
    prog(1, 32'h0000_0041, 32'h1203_0000);
    a0 = acc;
    irq_in[1] = 1'b1; wait_n(6);
    chk("R5 one message on rise", acc - a0, 1);
    chk("R11 edge vector", last_vec, 32'h41);
    wait_n(6);
    chk("R5 no repeat while held", acc - a0, 1);
    irq_in[1] = 1'b0; wait_n(3);

    // R6: masked edge discarded
    prog(1, 32'h0001_0041, 32'h1203_0000);
    a0 = acc;
    irq_in[1] = 1'b1; wait_n(4); irq_in[1] = 1'b0; wait_n(3);
    wr(8'h10, 32'h0000_0041);
    wait_n(6);
    chk("R6 masked edge not delivered", acc - a0, 0);

    // R7 / R8: two level entries sharing a vector
    prog(3, 32'h0000_8152, 32'hABCD_0000);
    prog(4, 32'h0000_8052, 32'h0);
    a0 = acc;
    irq_in[3] = 1'b1; irq_in[4] = 1'b1; wait_n(6);
    chk("R7 level messages", acc - a0, 2);
    wait_n(6);
    chk("R7 silent while in service", acc - a0, 2);
    wr(8'h40, 32'h99); wait_n(6);
    chk("R8 other vector keeps in service", acc - a0, 2);
    wr(8'h40, 32'h52); wait_n(6);
    chk("R8 shared eoi re-delivers both", acc - a0, 4);
    irq_in[3] = 1'b0; irq_in[4] = 1'b0; wait_n(3);
    wr(8'h40, 32'h52); wait_n(6);
    chk("R8 released and idle", acc - a0, 4);

    // R10: lowest index first, held while not ready
    msg_ready = 1'b0;
    irq_in[3] = 1'b1; irq_in[4] = 1'b1; wait_n(3);
    #2;
    chk("R10 valid held", msg_valid, 1);
    chk("R10 lowest index dest", msg_dest, 16'hABCD);
    step(); wait_n(2); #2;
    chk("R10 still offered", msg_valid, 1);
    step();
    msg_ready = 1'b1; wait_n(4);
    irq_in[3] = 1'b0; irq_in[4] = 1'b0; wait_n(3);
    wr(8'h40, 32'h52); wait_n(3);

    // R9: active-low level entry
    a0 = acc;
    prog(5, 32'h0000_A063, 32'h0500_0000);
    wait_n(6);
    chk("R9 low input active", acc - a0, 1);
    chk("R9 vector", last_vec, 32'h63);
    irq_in[5] = 1'b1; wait_n(3);
    wr(8'h40, 32'h63); wait_n(6);
    chk("R9 high input inactive", acc - a0, 1);
    irq_in[5] = 1'b0; wait_n(6);
    chk("R9 low again delivers", acc - a0, 2);
    wr(8'h10, 32'h0001_A063); wr(8'h40, 32'h63); wait_n(3);

    // R11: delivery mode and destination on the port
    prog(6, 32'h0000_0577, 32'h00FF_0000);
    msg_ready = 1'b0;
    irq_in[6] = 1'b1; wait_n(4);
    #2;
    chk("R11 valid", msg_valid, 1);
    chk("R11 vector", msg_vector, 8'h77);
    chk("R11 dmode INIT", msg_dmode, 3'd5);
    chk("R11 dest", msg_dest, 16'h00FF);
    step();
    msg_ready = 1'b1; wait_n(4);
    irq_in[6] = 1'b0; wait_n(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule